// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block produces the carrier sense, collision and qualified receive-error indications that a 10/100 Ethernet PHY presents to its MAC. At 100 Mb/s it follows a stream of already-decoded 4B/5B symbol codes. Carrier rises on the start-of-stream pair and falls on the end-of-stream pair. As a fallback, carrier also falls when an idle symbol shows up while no end pair has closed the stream. At 10 Mb/s it follows two strobes from the receive path: one marks a valid preamble and one marks the end of a frame.

Collision is reported only in half-duplex operation, and only while the local transmitter and the receiver are busy at the same time. The raw error strobe from the decoder reaches the receive-error output only while receive data is marked valid. All outputs are registered in the receive clock domain. Synchronous reset clears all of them.

Top module: `mii_crs_col`

## Requirements
- R1: After a clock edge with `rst` high, `crs`, `col` and `rx_er` are all low.
- R2: With `speed_100` high, a valid J symbol (code 2) followed by a valid K symbol (code 3) sets `crs` high from the edge that samples the K. Other codes are DATA=0, IDLE=1, T=4, R=5, BAD=6 and SPARE=7.
- R3: A J followed by any valid symbol other than K or J leaves `crs` low and restarts the search. A J followed by another J stays armed, so J J K asserts `crs`.
- R4: Cycles with `sym_vld` low are ignored by the symbol tracker. A pair split by such cycles still counts as consecutive.
- R5: While `crs` is high at 100 Mb/s, a valid T (4) followed by a valid R (5) clears `crs` from the edge that samples the R.
- R6: While `crs` is high at 100 Mb/s, a valid IDLE (1) clears `crs` from the edge that samples it, even without a T/R pair. This includes an IDLE that directly follows a T.
- R7: A T followed by a valid symbol other than R, IDLE or T leaves `crs` high. T T R still clears it.
- R8: With `speed_100` low, `pre_ok` sets `crs` and `eof_stb` clears it. When both are high in one cycle, `eof_stb` wins. Symbol codes have no effect in this mode.
- R9: `col` after an edge equals `!full_dup && tx_en && crs`, sampled just before that edge. It stays low in full duplex.
- R10: `rx_er` after an edge equals `rx_dv && err_raw`, sampled just before that edge. An error strobe while `rx_dv` is low has no effect.
- R11: A change of `speed_100` clears the carrier state of the mode being left, at the edge that samples the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_100 | input | 1 | 1 selects 100 Mb/s symbol tracking, 0 selects 10 Mb/s strobes |
| full_dup | input | 1 | 1 selects full duplex |
| sym_vld | input | 1 | Symbol code valid strobe |
| sym_code | input | 3 | Decoded symbol code |
| pre_ok | input | 1 | 10 Mb/s valid preamble strobe |
| eof_stb | input | 1 | 10 Mb/s end-of-frame strobe |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx_dv | input | 1 | Receive data valid |
| err_raw | input | 1 | Unqualified receive error strobe |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| rx_er | output | 1 | Qualified receive error |

## Verification
The symbol tracker is driven with clean J K ... T R frames, with broken starts (J DATA, J J K), and with pairs split by invalid cycles. These patterns separate a true pair detector from one that reacts to a lone K or loses state across gaps. End-of-stream is tried with a proper T R, with a bare IDLE, with T IDLE, with T DATA and with T T R. These show whether the fallback drop and the T re-arm behave independently of the normal end pair. At 10 Mb/s, simultaneous preamble and end strobes expose the priority. Collision and error gating are swept over every duplex, transmit and data-valid combination, and speed is switched in mid-carrier.

// File: rtl/mii_cc_pkg.sv
package mii_cc_pkg;
    parameter int SYM_W = 3;

    typedef enum logic [SYM_W-1:0] {
        SYM_DATA  = 3'd0,
        SYM_IDLE  = 3'd1,
        SYM_J     = 3'd2,
        SYM_K     = 3'd3,
        SYM_T     = 3'd4,
        SYM_R     = 3'd5,
        SYM_BAD   = 3'd6,
        SYM_SPARE = 3'd7
    } sym_e;

    typedef enum logic [1:0] {
        TRK_HUNT  = 2'd0,
        TRK_ARMED = 2'd1,
        TRK_CARRY = 2'd2,
        TRK_CLOSE = 2'd3
    } trk_e;
endpackage

// File: rtl/cc_stream_track.sv
module cc_stream_track
    import mii_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sym_vld,
    input  logic [SYM_W-1:0] sym_code,
    output logic             carrier
);
    typedef struct packed {
        trk_e st;
    } trk_regs_t;

    trk_regs_t r_d, r_q;
    sym_e      sym;

    always_comb begin
        sym = sym_e'(sym_code);
        r_d = r_q;
        if (!en) begin
            r_d.st = TRK_HUNT;
        end else if (sym_vld) begin
            unique case (r_q.st)
                TRK_HUNT:  r_d.st = (sym == SYM_J) ? TRK_ARMED : TRK_HUNT;
                TRK_ARMED: begin
                    if (sym == SYM_K)      r_d.st = TRK_CARRY;
                    else if (sym == SYM_J) r_d.st = TRK_ARMED;
                    else                   r_d.st = TRK_HUNT;
                end
                TRK_CARRY: begin
                    if (sym == SYM_T)         r_d.st = TRK_CLOSE;
                    else if (sym == SYM_IDLE) r_d.st = TRK_HUNT;
                    else                      r_d.st = TRK_CARRY;
                end
                TRK_CLOSE: begin
                    if (sym == SYM_R || sym == SYM_IDLE) r_d.st = TRK_HUNT;
                    else if (sym == SYM_T)               r_d.st = TRK_CLOSE;
                    else                                 r_d.st = TRK_CARRY;
                end
                default:   r_d.st = TRK_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: TRK_HUNT};
        else     r_q <= r_d;
    end

    assign carrier = (r_q.st == TRK_CARRY) || (r_q.st == TRK_CLOSE);
endmodule

// File: rtl/cc_frame_track.sv
module cc_frame_track (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pre_ok,
    input  logic eof_stb,
    output logic carrier
);
    typedef struct packed {
        logic on;
    } frm_regs_t;

    frm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en || eof_stb) r_d.on = 1'b0;
        else if (pre_ok)    r_d.on = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{on: 1'b0};
        else     r_q <= r_d;
    end

    assign carrier = r_q.on;
endmodule

// File: rtl/cc_col_err.sv
module cc_col_err (
    input  logic clk,
    input  logic rst,
    input  logic full_dup,
    input  logic tx_en,
    input  logic crs,
    input  logic rx_dv,
    input  logic err_raw,
    output logic col,
    output logic rx_er
);
    typedef struct packed {
        logic col;
        logic er;
    } ce_regs_t;

    ce_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.col = !full_dup && tx_en && crs;
        r_d.er  = rx_dv && err_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{col: 1'b0, er: 1'b0};
        else     r_q <= r_d;
    end

    assign col   = r_q.col;
    assign rx_er = r_q.er;
endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col
    import mii_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             speed_100,
    input  logic             full_dup,
    input  logic             sym_vld,
    input  logic [SYM_W-1:0] sym_code,
    input  logic             pre_ok,
    input  logic             eof_stb,
    input  logic             tx_en,
    input  logic             rx_dv,
    input  logic             err_raw,
    output logic             crs,
    output logic             col,
    output logic             rx_er
);
    logic car_fast;
    logic car_slow;

    cc_stream_track u_fast (
        .clk      (clk),
        .rst      (rst),
        .en       (speed_100),
        .sym_vld  (sym_vld),
        .sym_code (sym_code),
        .carrier  (car_fast)
    );

    cc_frame_track u_slow (
        .clk     (clk),
        .rst     (rst),
        .en      (!speed_100),
        .pre_ok  (pre_ok),
        .eof_stb (eof_stb),
        .carrier (car_slow)
    );

    assign crs = car_fast || car_slow;

    cc_col_err u_ce (
        .clk      (clk),
        .rst      (rst),
        .full_dup (full_dup),
        .tx_en    (tx_en),
        .crs      (crs),
        .rx_dv    (rx_dv),
        .err_raw  (err_raw),
        .col      (col),
        .rx_er    (rx_er)
    );
endmodule

// File: rtl/mii_crs_col_chk.sv
module mii_crs_col_chk
    import mii_cc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             speed_100,
    input logic             full_dup,
    input logic             sym_vld,
    input logic [SYM_W-1:0] sym_code,
    input logic             pre_ok,
    input logic             eof_stb,
    input logic             tx_en,
    input logic             rx_dv,
    input logic             err_raw,
    input logic             crs,
    input logic             col,
    input logic             rx_er
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!crs && !col && !rx_er));

    // R9
    a_r9_full_dup_quiet: assert property (@(posedge clk) disable iff (rst)
        full_dup |=> !col);

    // R9
    a_r9_col_needs_both: assert property (@(posedge clk) disable iff (rst)
        (!tx_en || !crs) |=> !col);

    // R10
    a_r10_er_needs_dv: assert property (@(posedge clk) disable iff (rst)
        !rx_dv |=> !rx_er);

    // R2, R8
    a_r2_crs_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(crs) |-> ($past(speed_100 && sym_vld && sym_code == SYM_K)
                        || $past(!speed_100 && pre_ok)));

    // R8
    a_r8_eof_drops: assert property (@(posedge clk) disable iff (rst)
        (!speed_100 && eof_stb) |=> !crs);
endmodule

bind mii_crs_col mii_crs_col_chk u_chk (.*);

// File: tb/mii_crs_col_test.sv
module mii_crs_col_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speed_100 = 1'b1, full_dup = 1'b0, sym_vld = 1'b0;
    logic [2:0] sym_code = 3'd0;
    logic       pre_ok = 1'b0, eof_stb = 1'b0, tx_en = 1'b0, rx_dv = 1'b0, err_raw = 1'b0;
    logic       crs, col, rx_er;

    mii_crs_col uut (.*);

    always #2.5 clk = ~clk;

    int    n_chk = 0, n_err = 0;
    string tag = "R1";
    int    m_st = 0;
    bit    m_c10 = 0, m_crs = 0, m_col = 0, m_er = 0;
    bit    done = 0;

    // behavioural reference: codes DATA0 IDLE1 J2 K3 T4 R5
    always @(posedge clk) begin
        bit old_crs;
        old_crs = m_crs;
        if (rst) begin
            m_st = 0; m_c10 = 0; m_col = 0; m_er = 0;
        end else begin
            if (!speed_100) m_st = 0;
            else if (sym_vld) begin
                if (m_st == 0)      m_st = (sym_code == 2) ? 1 : 0;
                else if (m_st == 1) m_st = (sym_code == 3) ? 2 : (sym_code == 2) ? 1 : 0;
                else if (m_st == 2) m_st = (sym_code == 4) ? 3 : (sym_code == 1) ? 0 : 2;
                else                m_st = (sym_code == 5 || sym_code == 1) ? 0 : (sym_code == 4) ? 3 : 2;
            end
            if (speed_100 || eof_stb) m_c10 = 0;
            else if (pre_ok)          m_c10 = 1;
            m_col = !full_dup && tx_en && old_crs;
            m_er  = rx_dv && err_raw;
        end
        m_crs = (m_st >= 2) || m_c10;
    end

    task automatic check(input string what, input bit act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check("crs", crs, m_crs);
        check("col", col, m_col);
        check("rx_er", rx_er, m_er);
    endtask

    task automatic sym(input int c);
        sym_vld = 1'b1; sym_code = 3'(c);
        tick();
        sym_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1"; idle(2);
        check("R1 crs", crs, 1'b0); check("R1 col", col, 1'b0); check("R1 rx_er", rx_er, 1'b0);
        rst = 1'b0;
        // R2 / R5 clean frame
        tag = "R2"; sym(1); sym(2); sym(3);
        check("R2 crs after JK", crs, 1'b1);
        sym(0); sym(0); sym(7);
        tag = "R5"; sym(4); sym(5);
        check("R5 crs after TR", crs, 1'b0);
        // R3 broken start and re-arm
        tag = "R3"; sym(2); sym(0); sym(3);
        check("R3 J DATA K", crs, 1'b0);
        sym(2); sym(2); sym(3);
        check("R3 J J K", crs, 1'b1);
        sym(4); sym(5);
        // R4 gaps between pair halves
        tag = "R4"; sym(2); idle(3); sym(3);
        check("R4 split JK", crs, 1'b1);
        idle(2); sym(4); idle(2); sym(5);
        check("R4 split TR", crs, 1'b0);
        // R6 idle fallback
        tag = "R6"; sym(2); sym(3); sym(0); sym(1);
        check("R6 idle drop", crs, 1'b0);
        sym(2); sym(3); sym(4); sym(1);
        check("R6 T idle drop", crs, 1'b0);
        // R7 T not followed by R
        tag = "R7"; sym(2); sym(3); sym(4); sym(0);
        check("R7 T DATA keeps", crs, 1'b1);
        sym(4); sym(4); sym(5);
        check("R7 T T R drops", crs, 1'b0);
        // R9 collision
        tag = "R9"; sym(2); sym(3);
        tx_en = 1'b1; tick(); check("R9 half col", col, 1'b1);
        full_dup = 1'b1; tick(); check("R9 full no col", col, 1'b0);
        full_dup = 1'b0; tick();
        tx_en = 1'b0; tick(); check("R9 tx off", col, 1'b0);
        tx_en = 1'b1; sym(4); sym(5); tick();
        check("R9 no crs no col", col, 1'b0);
        tx_en = 1'b0;
        // R10 error qualification
        tag = "R10"; err_raw = 1'b1; tick();
        check("R10 err without dv", rx_er, 1'b0);
        rx_dv = 1'b1; tick(); check("R10 err with dv", rx_er, 1'b1);
        err_raw = 1'b0; tick(); check("R10 err gone", rx_er, 1'b0);
        rx_dv = 1'b0; tick();
        // R11 speed switch mid carrier
        tag = "R11"; sym(2); sym(3);
        speed_100 = 1'b0; tick();
        check("R11 fast carrier cleared", crs, 1'b0);
        // R8 ten-megabit strobes
        tag = "R8"; sym(2); sym(3);
        check("R8 symbols ignored", crs, 1'b0);
        pre_ok = 1'b1; tick(); pre_ok = 1'b0;
        check("R8 preamble sets", crs, 1'b1);
        idle(2);
        eof_stb = 1'b1; tick(); eof_stb = 1'b0;
        check("R8 eof clears", crs, 1'b0);
        pre_ok = 1'b1; eof_stb = 1'b1; tick();
        check("R8 eof priority idle", crs, 1'b0);
        eof_stb = 1'b0; tick();
        eof_stb = 1'b1; tick(); pre_ok = 1'b0; eof_stb = 1'b0;
        check("R8 eof priority busy", crs, 1'b0);
        tag = "R11"; pre_ok = 1'b1; tick(); pre_ok = 1'b0;
        speed_100 = 1'b1; tick();
        check("R11 slow carrier cleared", crs, 1'b0);
        tag = "R1"; sym(2); sym(3); rst = 1'b1; tick();
        check("R1 reset mid frame", crs, 1'b0);
        rst = 1'b0; idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule